// File: doc/BRIEF.md
# Control-Flow Checking Watchdog

This block sits beside a processor's instruction fetch path and watches every fetched word together with its address. A fetch whose address is one more than the one before is treated as straight-line execution. Any other address means the previous instruction was a taken branch, jump or call. Each such transfer is checked in two ways. First, the (source, target) pair must appear in a preloaded table of legal edges. Second, the instruction run that has just ended must produce the signature that a second preloaded table holds for that run's start address.

Both tables are written through a simple load port before monitoring starts. They are searched one entry per cycle. While a search is running, the snoop port drops its ready signal. The first failure found raises a sticky error flag and captures a cause code and the target address of the offending transfer. These stay until software writes a clear.

Top module: `ctrl_flow_watchdog`

## Requirements
- R1: After synchronous reset, err_flag is 0, err_cause is 0, err_addr is 0 and fetch_ready is 1.
- R2: A fetch is accepted on a clock edge where fetch_valid and fetch_ready are both 1. An accepted fetch whose address equals the previous accepted address plus one starts no check, and fetch_ready stays 1.
- R3: An accepted fetch whose address is not the previous address plus one (with an earlier fetch since reset) starts a search. fetch_ready is 0 for exactly N+1 cycles after the accepting edge, where N is the table depth. The error outputs update on the same edge where fetch_ready returns to 1.
- R4: A transfer whose (previous address, new address) pair matches no valid edge entry sets err_flag with err_cause 1, and err_addr takes the new address. A matching valid entry in any slot, including the last, raises no edge error.
- R5: The signature is 16 bits wide. Each accepted fetch folds its 32-bit word to 16 bits by XOR of the upper and lower halves. A fetch that starts a run loads the signature with the folded value. Every other fetch rotates the signature left by one bit and XORs in the folded value. A run starts at the first fetch after reset and at each transfer. At a transfer, the ended run's signature must equal that of a valid signature entry whose key is the run's start address. A mismatch, or no entry with that key, gives err_cause 2.
- R6: When a transfer fails both checks, err_cause is 1.
- R7: While err_flag is 1 and err_clr is not asserted, later failures leave err_flag, err_cause and err_addr unchanged.
- R8: err_clr high at a clock edge clears err_flag, err_cause and err_addr. If a search that finds a failure finishes on that same edge, the new failure is captured instead.
- R9: A load write with tbl_sel 0 writes edge slot tbl_idx (key = source, tbl_dst = target). A write with tbl_sel 1 writes signature slot tbl_idx (key = start address, tbl_sig = signature). tbl_vld sets the slot's valid bit, so a write with tbl_vld 0 removes the entry. Reset marks all slots invalid.
- R10: The address increment wraps, so a fetch at address 0 after one at the all-ones address counts as sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Snooped fetch present |
| fetch_addr | input | AW | Word address of the fetch |
| fetch_insn | input | IW | Fetched instruction word |
| fetch_ready | output | 1 | Low while a table search runs |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 edge table, 1 signature table |
| tbl_idx | input | IDXW | Slot index |
| tbl_vld | input | 1 | Valid bit written into the slot |
| tbl_key | input | AW | Edge source or run start address |
| tbl_dst | input | AW | Edge target address |
| tbl_sig | input | SW | Expected run signature |
| err_clr | input | 1 | Software clear of the error state |
| err_flag | output | 1 | Sticky error |
| err_cause | output | 2 | 1 illegal edge, 2 signature fault |
| err_addr | output | AW | Target address of the first failing transfer |

## Verification
A corrupted running signature or a wrong run-start register only shows at the ports at the next transfer, N+1 cycles after that transfer is accepted, as a spurious or missing cause 2. The bench therefore ends runs both of full and of truncated length and checks each result. A stuck search counter shows at once as a busy window on fetch_ready whose length is not N+1. A broken sticky path shows as a cause or address that changes at a later transfer while the flag is still set.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_EDGE = 2'd1,
    CAUSE_SIG  = 2'd2
  } cause_e;
endpackage

// File: rtl/cfw_sig.sv
// Running signature of a branch-free run: rotate left by one, XOR folded word.
module cfw_sig #(
  parameter int IW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          restart,
  input  logic [IW-1:0] insn,
  output logic [SW-1:0] sig
);
  localparam int NCH = IW / SW;

  logic [SW-1:0] part [NCH];
  logic [SW-1:0] fold;

  assign part[0] = insn[SW-1:0];
  for (genvar g = 1; g < NCH; g++) begin : g_fold
    assign part[g] = part[g-1] ^ insn[g*SW +: SW];
  end
  assign fold = part[NCH-1];

  always_ff @(posedge clk) begin
    if (rst)       sig <= '0;
    else if (step) sig <= restart ? fold : ({sig[SW-2:0], sig[SW-1]} ^ fold);
  end
endmodule

// File: rtl/cfw_table.sv
// Key/data table with registered read (block RAM friendly) and reset valid bits.
module cfw_table #(
  parameter int N  = 32,
  parameter int KW = 16,
  parameter int DW = 16,
  localparam int XW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [XW-1:0] wr_idx,
  input  logic          wr_vld,
  input  logic [KW-1:0] wr_key,
  input  logic [DW-1:0] wr_data,
  input  logic [XW-1:0] rd_idx,
  output logic          rd_vld,
  output logic [KW-1:0] rd_key,
  output logic [DW-1:0] rd_data
);
  logic [KW+DW-1:0] mem [N];
  logic [KW+DW-1:0] rd_word;
  logic [N-1:0]     vld;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_key, wr_data};
    rd_word <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= wr_vld;
      rd_vld <= vld[rd_idx];
    end
  end

  assign rd_key  = rd_word[KW+DW-1:DW];
  assign rd_data = rd_word[DW-1:0];
endmodule

// File: rtl/ctrl_flow_watchdog.sv
module ctrl_flow_watchdog
  import cfw_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 32,
  parameter int SW = 16,
  parameter int N  = 32,
  localparam int IDXW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [AW-1:0]   fetch_addr,
  input  logic [IW-1:0]   fetch_insn,
  output logic            fetch_ready,
  input  logic            tbl_we,
  input  logic            tbl_sel,
  input  logic [IDXW-1:0] tbl_idx,
  input  logic            tbl_vld,
  input  logic [AW-1:0]   tbl_key,
  input  logic [AW-1:0]   tbl_dst,
  input  logic [SW-1:0]   tbl_sig,
  input  logic            err_clr,
  output logic            err_flag,
  output logic [1:0]      err_cause,
  output logic [AW-1:0]   err_addr
);
  localparam int STW = $clog2(N + 1);
  localparam logic [STW-1:0] LAST = STW'(N);

  logic            srch;
  logic [STW-1:0]  step;
  logic            have_prev;
  logic [AW-1:0]   prev_addr, blk_start;
  logic [AW-1:0]   chk_src, chk_dst, chk_start;
  logic [SW-1:0]   chk_sig, sig;
  logic            edge_hit, sig_hit;

  logic            e_vld, s_vld;
  logic [AW-1:0]   e_src, e_dst, s_key;
  logic [SW-1:0]   s_sig;

  logic accept, seq, restart, jump, cmp, done;
  logic e_match, s_match, edge_ok, sig_ok;
  cause_e new_cause;

  assign fetch_ready = !srch;
  assign accept  = fetch_valid && !srch;
  assign seq     = (fetch_addr == prev_addr + 1'b1);
  assign restart = !have_prev || !seq;
  assign jump    = accept && have_prev && !seq;
  assign cmp     = srch && (step != '0);
  assign done    = srch && (step == LAST);

  cfw_sig #(.IW(IW), .SW(SW)) u_sig (
    .clk(clk), .rst(rst), .step(accept), .restart(restart),
    .insn(fetch_insn), .sig(sig)
  );

  cfw_table #(.N(N), .KW(AW), .DW(AW)) u_edges (
    .clk(clk), .rst(rst),
    .wr_en(tbl_we && !tbl_sel), .wr_idx(tbl_idx), .wr_vld(tbl_vld),
    .wr_key(tbl_key), .wr_data(tbl_dst),
    .rd_idx(step[IDXW-1:0]), .rd_vld(e_vld), .rd_key(e_src), .rd_data(e_dst)
  );

  cfw_table #(.N(N), .KW(AW), .DW(SW)) u_sigs (
    .clk(clk), .rst(rst),
    .wr_en(tbl_we && tbl_sel), .wr_idx(tbl_idx), .wr_vld(tbl_vld),
    .wr_key(tbl_key), .wr_data(tbl_sig),
    .rd_idx(step[IDXW-1:0]), .rd_vld(s_vld), .rd_key(s_key), .rd_data(s_sig)
  );

  assign e_match = cmp && e_vld && (e_src == chk_src) && (e_dst == chk_dst);
  assign s_match = cmp && s_vld && (s_key == chk_start) && (s_sig == chk_sig);
  assign edge_ok = edge_hit || e_match;
  assign sig_ok  = sig_hit || s_match;

  always_comb begin
    if (!edge_ok)     new_cause = CAUSE_EDGE;
    else if (!sig_ok) new_cause = CAUSE_SIG;
    else              new_cause = CAUSE_NONE;
  end

  // Fetch tracking and search sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      srch      <= 1'b0;
      step      <= '0;
      have_prev <= 1'b0;
      prev_addr <= '0;
      blk_start <= '0;
      chk_src   <= '0;
      chk_dst   <= '0;
      chk_start <= '0;
      chk_sig   <= '0;
      edge_hit  <= 1'b0;
      sig_hit   <= 1'b0;
    end else begin
      if (accept) begin
        have_prev <= 1'b1;
        prev_addr <= fetch_addr;
        if (restart) blk_start <= fetch_addr;
      end
      if (jump) begin
        srch      <= 1'b1;
        step      <= '0;
        edge_hit  <= 1'b0;
        sig_hit   <= 1'b0;
        chk_src   <= prev_addr;
        chk_dst   <= fetch_addr;
        chk_start <= blk_start;
        chk_sig   <= sig;
      end
      if (srch) begin
        edge_hit <= edge_ok;
        sig_hit  <= sig_ok;
        if (done) srch <= 1'b0;
        else      step <= step + 1'b1;
      end
    end
  end

  // Sticky error capture
  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag  <= 1'b0;
      err_cause <= 2'd0;
      err_addr  <= '0;
    end else begin
      if (err_clr) begin
        err_flag  <= 1'b0;
        err_cause <= 2'd0;
        err_addr  <= '0;
      end
      if (done && (new_cause != CAUSE_NONE) && (!err_flag || err_clr)) begin
        err_flag  <= 1'b1;
        err_cause <= new_cause;
        err_addr  <= chk_dst;
      end
    end
  end

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag && !err_clr |=> err_flag);
  // R7
  sticky_info_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag && !err_clr |=> $stable(err_cause) && $stable(err_addr));
  // R4
  cause_legal_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (err_cause == 2'd1 || err_cause == 2'd2));
  // R3
  busy_after_jump_chk: assert property (@(posedge clk) disable iff (rst)
    jump |=> !fetch_ready);
  // R3
  search_bound_chk: assert property (@(posedge clk) disable iff (rst)
    srch |-> step <= LAST);
  // R2
  seq_no_search_chk: assert property (@(posedge clk) disable iff (rst)
    accept && have_prev && seq |=> fetch_ready);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    err_clr && !done |=> !err_flag);
endmodule

// File: tb/sim_ctrl_flow_watchdog.sv
module sim_ctrl_flow_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 32;
  localparam int SW = 16;
  localparam int N  = 32;
  localparam int IDXW = $clog2(N);

  logic clk, rst;
  logic fetch_valid, fetch_ready;
  logic [AW-1:0] fetch_addr;
  logic [IW-1:0] fetch_insn;
  logic tbl_we, tbl_sel, tbl_vld;
  logic [IDXW-1:0] tbl_idx;
  logic [AW-1:0] tbl_key, tbl_dst;
  logic [SW-1:0] tbl_sig;
  logic err_clr, err_flag;
  logic [1:0] err_cause;
  logic [AW-1:0] err_addr;

  int checks = 0;
  int errors = 0;

  ctrl_flow_watchdog #(.AW(AW), .IW(IW), .SW(SW), .N(N)) u0 (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_insn(fetch_insn),
    .fetch_ready(fetch_ready),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_vld(tbl_vld),
    .tbl_key(tbl_key), .tbl_dst(tbl_dst), .tbl_sig(tbl_sig),
    .err_clr(err_clr), .err_flag(err_flag), .err_cause(err_cause), .err_addr(err_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench-side picture of the tables and the expected error state
  logic [AW-1:0] me_src [N];
  logic [AW-1:0] me_dst [N];
  bit            me_v   [N];
  logic [AW-1:0] ms_key [N];
  logic [SW-1:0] ms_sig [N];
  bit            ms_v   [N];
  bit            m_have;
  logic [AW-1:0] m_prev, m_start;
  logic [SW-1:0] m_sig;
  bit            m_flag;
  logic [1:0]    m_cause;
  logic [AW-1:0] m_addr;
  logic [AW+2:0] exp_q [$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] fold(logic [IW-1:0] w);
    return w[31:16] ^ w[15:0];
  endfunction

  function automatic logic [IW-1:0] insn_of(logic [AW-1:0] a);
    return {a ^ 16'hA5A5, a * 16'd257 + 16'h003C};
  endfunction

  function automatic logic [SW-1:0] run_sig(logic [AW-1:0] start, int len);
    logic [SW-1:0] s;
    s = fold(insn_of(start));
    for (int i = 1; i < len; i++) s = {s[SW-2:0], s[SW-1]} ^ fold(insn_of(start + AW'(i)));
    return s;
  endfunction

  task automatic ld_edge(int idx, logic [AW-1:0] src, logic [AW-1:0] dst, bit v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 1'b0; tbl_idx = IDXW'(idx); tbl_vld = v;
    tbl_key = src; tbl_dst = dst;
    me_src[idx] = src; me_dst[idx] = dst; me_v[idx] = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic ld_sig(int idx, logic [AW-1:0] start, logic [SW-1:0] s, bit v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 1'b1; tbl_idx = IDXW'(idx); tbl_vld = v;
    tbl_key = start; tbl_sig = s;
    ms_key[idx] = start; ms_sig[idx] = s; ms_v[idx] = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Driver: one fetch; pushes the expected outcome of any transfer it makes
  task automatic fetch(logic [AW-1:0] a, logic [IW-1:0] w, bit clr_at_end);
    bit seq, jmp, e_ok, s_ok;
    logic [1:0] cause;
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; fetch_insn = w;
    seq = m_have && (a == AW'(m_prev + 1'b1));
    jmp = m_have && !seq;
    if (jmp) begin
      e_ok = 0; s_ok = 0;
      for (int i = 0; i < N; i++) begin
        if (me_v[i] && me_src[i] == m_prev && me_dst[i] == a) e_ok = 1;
        if (ms_v[i] && ms_key[i] == m_start && ms_sig[i] == m_sig) s_ok = 1;
      end
      cause = !e_ok ? 2'd1 : (!s_ok ? 2'd2 : 2'd0);
      if (clr_at_end) begin m_flag = 0; m_cause = 0; m_addr = 0; end
      if (!m_flag && cause != 0) begin m_flag = 1; m_cause = cause; m_addr = a; end
      exp_q.push_back({m_flag, m_cause, m_addr});
    end
    if (!seq) begin m_sig = fold(w); m_start = a; end
    else      m_sig = {m_sig[SW-2:0], m_sig[SW-1]} ^ fold(w);
    m_have = 1; m_prev = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    if (jmp)             chk("R3", "ready drops after transfer", fetch_ready, 0);
    else if (a == '0 && seq) chk("R10", "wrap is sequential, ready", fetch_ready, 1);
    else                 chk("R2", "ready after straight fetch", fetch_ready, 1);
    if (jmp && clr_at_end) begin
      repeat (N) @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
    end
  endtask

  task automatic run(logic [AW-1:0] start, int len, int bad, bit clr_first);
    for (int i = 0; i < len; i++) begin
      logic [AW-1:0] a;
      a = start + AW'(i);
      fetch(a, insn_of(a) ^ ((i == bad) ? 32'h1 : 32'h0), clr_first && i == 0);
    end
  endtask

  task automatic clear_err();
    @(negedge clk);
    while (!fetch_ready) @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    m_flag = 0; m_cause = 0; m_addr = 0;
    chk("R8", "flag after clear", err_flag, 0);
    chk("R8", "cause after clear", err_cause, 0);
    chk("R8", "addr after clear", err_addr, 0);
  endtask

  // Monitor: busy window length and outcome of each search
  initial begin
    int busy;
    bit prev_rdy;
    logic [AW+2:0] e;
    busy = 0; prev_rdy = 1;
    forever begin
      @(negedge clk);
      if (rst) begin
        busy = 0; prev_rdy = 1;
      end else begin
        if (!fetch_ready) busy++;
        else if (!prev_rdy) begin
          chk("R3", "busy cycles", busy, N + 1);
          if (exp_q.size() == 0) chk("R3", "unexpected search", 1, 0);
          else begin
            e = exp_q.pop_front();
            chk("R4 R5 R6 R7 R8 R9", "err_flag", err_flag, e[AW+2]);
            chk("R4 R5 R6 R7 R8 R9", "err_cause", err_cause, e[AW+1:AW]);
            chk("R4 R5 R6 R7 R8 R9", "err_addr", err_addr, e[AW-1:0]);
          end
          busy = 0;
        end
        prev_rdy = fetch_ready;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; fetch_valid = 0; fetch_addr = 0; fetch_insn = 0;
    tbl_we = 0; tbl_sel = 0; tbl_idx = 0; tbl_vld = 0;
    tbl_key = 0; tbl_dst = 0; tbl_sig = 0; err_clr = 0;
    m_have = 0; m_prev = 0; m_start = 0; m_sig = 0;
    m_flag = 0; m_cause = 0; m_addr = 0;
    for (int i = 0; i < N; i++) begin
      me_v[i] = 0; ms_v[i] = 0; me_src[i] = 0; me_dst[i] = 0; ms_key[i] = 0; ms_sig[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset err_flag", err_flag, 0);
    chk("R1", "reset err_cause", err_cause, 0);
    chk("R1", "reset err_addr", err_addr, 0);
    chk("R1", "reset fetch_ready", fetch_ready, 1);

    // R9 table loads
    ld_edge(0, 16'h0013, 16'h0040, 1);
    ld_edge(5, 16'h0042, 16'h0010, 1);
    ld_edge(N-1, 16'h0013, 16'h0100, 1);
    ld_edge(7, 16'h0101, 16'h0010, 1);
    ld_sig(0, 16'h0010, run_sig(16'h0010, 4), 1);
    ld_sig(1, 16'h0040, run_sig(16'h0040, 3), 1);

    run(16'h0010, 4, -1, 0);  // first run, no check
    run(16'h0040, 3, -1, 0);  // R4 R5 legal edge and signature
    run(16'h0010, 3, -1, 0);  // legal
    run(16'h0040, 3, -1, 0);  // R6 short run: edge and signature both fail -> 1
    run(16'h0010, 4, 1, 0);   // R7 legal, error held
    run(16'h0040, 3, -1, 0);  // R7 signature fault hidden by sticky state
    clear_err();
    run(16'h0010, 4, -1, 0);  // legal
    run(16'h0040, 3, 2, 0);   // legal transfer, corrupt run
    run(16'h0010, 4, -1, 0);  // R5 corrupted run -> cause 2
    clear_err();
    run(16'h0100, 2, -1, 0);  // R4 edge in last slot
    run(16'h0010, 4, -1, 0);  // R5 run with no signature entry -> cause 2
    ld_edge(0, 16'h0013, 16'h0040, 0);  // R9 remove edge
    run(16'h0040, 3, -1, 1);  // R8 clear on finishing edge, R9 removed -> cause 1
    clear_err();
    run(16'hFFFE, 3, -1, 0);  // R10 wrap through zero
    repeat (N + 4) @(negedge clk);
    chk("R3", "pending results", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule